// File: doc/BRIEF.md
# Block-Aligned Instruction Fetch with Decode Queue

This block sits between the instruction cache and the decode stage of an in-order multiple-issue core. Each cycle it presents a fetch address and receives the whole cache block that contains it, together with one branch prediction for that block. From the block it takes the run of 4-byte instructions that begins at the fetch address. The run stops at the last slot of the block or at a branch predicted taken, whichever comes first. The run is written into a circular instruction queue, and the fetch address moves on to the next block or to the predicted target.

The number of instructions a fetch delivers depends on where the address falls in the block and on taken branches. The queue absorbs this variation, so decode can keep taking up to its full width per cycle. Decode sees the oldest queue entries on the head outputs. Each entry carries the instruction word, its byte address and a flag that marks the branch predicted taken. A misprediction redirect empties the queue and restarts fetch at the corrected address.

Back-pressure works as follows. Head slot i is valid only when slots 0..i-1 are valid. Decode takes a prefix of the head by driving `deq_cnt`, and the queue clamps a request larger than the number of valid slots. Fetch is throttled in two cases: when the queue has fewer than one block's worth of free entries, and when the cache reports a miss. In either case the fetch address holds and nothing is written. The cache is expected to answer combinationally for the address on `fetch_pc`.

Top module: `fetch_block_unit`

## Requirements
- R1: After reset `fetch_pc` equals `RESET_PC`, `q_count` is 0 and every `head_valid` bit is 0.
- R2: A fetch that starts at slot 0 of a block with no taken prediction pushes all `BLOCK_INSNS` instructions. Each entry holds its word from `blk_data`, where slot s is bits [32*s+31:32*s], and its address, block base + 4*s. The next `fetch_pc` is block base + 4*`BLOCK_INSNS`.
- R3: A fetch that starts at slot s pushes only slots s to the last slot. A start at the last slot pushes exactly one instruction.
- R4: When `bp_taken` is high and `bp_slot` is at or after the start slot, the run ends at `bp_slot`. Only that entry has its taken flag set, and the next `fetch_pc` is `bp_target`.
- R5: A taken prediction whose `bp_slot` lies before the start slot has no effect. The fetch behaves as in R3 and moves on to the following block.
- R6: While `blk_hit` is low nothing is pushed and `fetch_pc` holds.
- R7: While fewer than `BLOCK_INSNS` queue entries are free, nothing is pushed and `fetch_pc` holds.
- R8: `head_*` slot i shows the i-th oldest entry. Each cycle the queue pops min(`deq_cnt`, `q_count`, `DEC_W`) entries and pushes the fetched run. `q_count` changes by pushes minus pops and never exceeds `Q_DEPTH`.
- R9: When `redir_valid` is high, the next cycle has `q_count` 0 and `fetch_pc` equal to `redir_pc`, whatever the pops, hit or prediction in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | output | 32 | Address presented to the cache this cycle |
| blk_data | input | 32*BLOCK_INSNS | Whole cache block for `fetch_pc`, slot 0 in the low bits |
| blk_hit | input | 1 | Cache hit for the presented address |
| bp_taken | input | 1 | A branch in this block is predicted taken |
| bp_slot | input | log2(BLOCK_INSNS) | Slot of the predicted branch |
| bp_target | input | 32 | Predicted target address |
| redir_valid | input | 1 | Misprediction redirect |
| redir_pc | input | 32 | Corrected fetch address |
| deq_cnt | input | log2(DEC_W+1) | Number of head entries decode takes this cycle |
| head_valid | output | DEC_W | Head slot valid, contiguous from bit 0 |
| head_insn | output | 32*DEC_W | Instruction words of the head slots |
| head_pc | output | 32*DEC_W | Addresses of the head slots |
| head_taken | output | DEC_W | Predicted-taken flags of the head slots |
| q_count | output | log2(Q_DEPTH+1) | Queue occupancy |

## Verification
Every result here is due one clock after the inputs that cause it: the new `fetch_pc`, the occupancy and the new head entries all appear after the edge that samples hit, prediction, pops and redirect. The bench changes inputs on the falling edge and reads outputs on the next falling edge. That places each read one rising edge after its stimulus. Table vectors isolate each fetch by redirecting first, so every check sees an empty queue and a single push. The directed part keeps hit low whenever it wants a pop without a push.

// File: rtl/fetchq_pkg.sv
package fetchq_pkg;
  parameter int AW = 32;
  parameter int IW = 32;

  typedef struct packed {
    logic [IW-1:0] insn;
    logic [AW-1:0] pc;
    logic          taken;
  } fq_entry_t;
endpackage

// File: rtl/fbu_run_slicer.sv
module fbu_run_slicer
  import fetchq_pkg::*;
#(
  parameter int BLOCK_INSNS = 4
) (
  input  logic [AW-1:0]                        fetch_pc,
  input  logic [BLOCK_INSNS*IW-1:0]            blk_data,
  input  logic                                 bp_taken,
  input  logic [$clog2(BLOCK_INSNS)-1:0]       bp_slot,
  input  logic [AW-1:0]                        bp_target,
  output logic [$clog2(BLOCK_INSNS+1)-1:0]     run_n,
  output fq_entry_t [BLOCK_INSNS-1:0]          run_ent,
  output logic [AW-1:0]                        next_pc
);
  localparam int SLOT_W  = $clog2(BLOCK_INSNS);
  localparam int PUSH_W  = $clog2(BLOCK_INSNS+1);
  localparam int BBYTES  = BLOCK_INSNS * 4;
  localparam logic [AW-1:0] OFS_MASK = AW'(BBYTES - 1);

  logic [SLOT_W-1:0] start;
  logic [SLOT_W-1:0] last;
  logic              br_live;
  logic [AW-1:0]     base;

  assign base    = fetch_pc & ~OFS_MASK;
  assign start   = fetch_pc[SLOT_W+1:2];
  // a prediction behind the fetch point is stale for this run
  assign br_live = bp_taken && (bp_slot >= start);
  assign last    = br_live ? bp_slot : SLOT_W'(BLOCK_INSNS - 1);
  assign run_n   = PUSH_W'(last) - PUSH_W'(start) + PUSH_W'(1);
  assign next_pc = br_live ? bp_target : base + AW'(BBYTES);

  for (genvar k = 0; k < BLOCK_INSNS; k++) begin : g_lane
    logic [SLOT_W:0] slot;
    assign slot = (SLOT_W+1)'(start) + (SLOT_W+1)'(k);
    always_comb begin
      run_ent[k] = '0;
      if (slot < (SLOT_W+1)'(BLOCK_INSNS)) begin
        run_ent[k].insn  = blk_data[slot[SLOT_W-1:0]*IW +: IW];
        run_ent[k].pc    = base + (AW'(slot) << 2);
        run_ent[k].taken = br_live && (slot[SLOT_W-1:0] == bp_slot);
      end
    end
  end
endmodule

// File: rtl/fbu_ring_queue.sv
module fbu_ring_queue
  import fetchq_pkg::*;
#(
  parameter int DEPTH    = 18,
  parameter int PUSH_MAX = 4,
  parameter int POP_MAX  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic [$clog2(PUSH_MAX+1)-1:0]     push_n,
  input  fq_entry_t [PUSH_MAX-1:0]          push_ent,
  input  logic [$clog2(POP_MAX+1)-1:0]      pop_req,
  output logic [$clog2(DEPTH+1)-1:0]        count,
  output fq_entry_t [POP_MAX-1:0]           head_ent,
  output logic [POP_MAX-1:0]                head_vld
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SUM_W  = IDX_W + 2;
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int PUSH_W = $clog2(PUSH_MAX+1);
  localparam int POP_W  = $clog2(POP_MAX+1);

  fq_entry_t          mem [DEPTH];
  logic [IDX_W-1:0]   head;
  logic [POP_W-1:0]   pop_n;
  logic [SUM_W-1:0]   tail_sum;

  function automatic logic [IDX_W-1:0] wrap(input logic [SUM_W-1:0] a);
    return (a >= SUM_W'(DEPTH)) ? IDX_W'(a - SUM_W'(DEPTH)) : IDX_W'(a);
  endfunction

  always_comb begin
    pop_n = pop_req;
    if (pop_n > POP_W'(POP_MAX)) pop_n = POP_W'(POP_MAX);
    if (SUM_W'(pop_n) > SUM_W'(count)) pop_n = POP_W'(count);
  end

  assign tail_sum = SUM_W'(head) + SUM_W'(count);

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_MAX; k++) begin
      if (PUSH_W'(k) < push_n)
        mem[wrap(tail_sum + SUM_W'(k))] <= push_ent[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      count <= '0;
    end else begin
      head  <= wrap(SUM_W'(head) + SUM_W'(pop_n));
      count <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  for (genvar i = 0; i < POP_MAX; i++) begin : g_head
    assign head_ent[i] = mem[wrap(SUM_W'(head) + SUM_W'(i))];
    assign head_vld[i] = CNT_W'(i) < count;
  end
endmodule

// File: rtl/fetch_block_unit.sv
module fetch_block_unit
  import fetchq_pkg::*;
#(
  parameter int          BLOCK_INSNS = 4,
  parameter int          Q_DEPTH     = 18,
  parameter int          DEC_W       = 2,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  output logic [31:0]                        fetch_pc,
  input  logic [BLOCK_INSNS*32-1:0]          blk_data,
  input  logic                               blk_hit,
  input  logic                               bp_taken,
  input  logic [$clog2(BLOCK_INSNS)-1:0]     bp_slot,
  input  logic [31:0]                        bp_target,
  input  logic                               redir_valid,
  input  logic [31:0]                        redir_pc,
  input  logic [$clog2(DEC_W+1)-1:0]         deq_cnt,
  output logic [DEC_W-1:0]                   head_valid,
  output logic [DEC_W*32-1:0]                head_insn,
  output logic [DEC_W*32-1:0]                head_pc,
  output logic [DEC_W-1:0]                   head_taken,
  output logic [$clog2(Q_DEPTH+1)-1:0]       q_count
);
  localparam int CNT_W  = $clog2(Q_DEPTH+1);
  localparam int PUSH_W = $clog2(BLOCK_INSNS+1);
  localparam int POP_W  = $clog2(DEC_W+1);

  logic [PUSH_W-1:0]              run_n;
  logic [PUSH_W-1:0]              push_n;
  fq_entry_t [BLOCK_INSNS-1:0]    run_ent;
  fq_entry_t [DEC_W-1:0]          head_ent;
  logic [AW-1:0]                  next_pc;
  logic                           room;
  logic                           fire;
  logic [POP_W-1:0]               pop_req;

  fbu_run_slicer #(.BLOCK_INSNS(BLOCK_INSNS)) u_slice (
    .fetch_pc (fetch_pc),
    .blk_data (blk_data),
    .bp_taken (bp_taken),
    .bp_slot  (bp_slot),
    .bp_target(bp_target),
    .run_n    (run_n),
    .run_ent  (run_ent),
    .next_pc  (next_pc)
  );

  // room for a whole block keeps the push path free of a partial-fit case
  assign room    = q_count <= CNT_W'(Q_DEPTH - BLOCK_INSNS);
  assign fire    = blk_hit && room && !redir_valid;
  assign push_n  = fire ? run_n : '0;
  assign pop_req = redir_valid ? '0 : deq_cnt;

  fbu_ring_queue #(
    .DEPTH   (Q_DEPTH),
    .PUSH_MAX(BLOCK_INSNS),
    .POP_MAX (DEC_W)
  ) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (redir_valid),
    .push_n  (push_n),
    .push_ent(run_ent),
    .pop_req (pop_req),
    .count   (q_count),
    .head_ent(head_ent),
    .head_vld(head_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           fetch_pc <= RESET_PC;
    else if (redir_valid) fetch_pc <= redir_pc;
    else if (fire)        fetch_pc <= next_pc;
  end

  for (genvar i = 0; i < DEC_W; i++) begin : g_out
    assign head_insn[i*32 +: 32] = head_ent[i].insn;
    assign head_pc[i*32 +: 32]   = head_ent[i].pc;
    assign head_taken[i]         = head_ent[i].taken;
  end
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
  parameter int BLOCK_INSNS = 4,
  parameter int Q_DEPTH     = 18
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [31:0]                   fetch_pc,
  input logic                          blk_hit,
  input logic                          bp_taken,
  input logic                          redir_valid,
  input logic [31:0]                   redir_pc,
  input logic [$clog2(Q_DEPTH+1)-1:0]  q_count
);
  localparam int CNT_W = $clog2(Q_DEPTH+1);
  localparam logic [31:0] MASK = 32'(BLOCK_INSNS*4 - 1);
  localparam logic [31:0] STEP = 32'(BLOCK_INSNS*4);

  logic room;
  assign room = q_count <= CNT_W'(Q_DEPTH - BLOCK_INSNS);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(Q_DEPTH));

  assert_push_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |=> (32'(q_count) <= 32'($past(q_count)) + 32'(BLOCK_INSNS)));

  assert_redirect_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (q_count == '0 && fetch_pc == $past(redir_pc)));

  assert_miss_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !blk_hit) |=> ($stable(fetch_pc) && q_count <= $past(q_count)));

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !room) |=> $stable(fetch_pc));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && blk_hit && room && !bp_taken)
      |=> fetch_pc == (($past(fetch_pc) & ~MASK) + STEP));
endmodule

bind fetch_block_unit fbu_checker #(
  .BLOCK_INSNS(BLOCK_INSNS),
  .Q_DEPTH    (Q_DEPTH)
) u_fbu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_pc   (fetch_pc),
  .blk_hit    (blk_hit),
  .bp_taken   (bp_taken),
  .redir_valid(redir_valid),
  .redir_pc   (redir_pc),
  .q_count    (q_count)
);

// File: tb/fetch_block_unit_test.sv
module fetch_block_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int BI = 4;
  localparam int QD = 18;
  localparam int DW = 2;

  typedef struct packed {
    logic [31:0] start;
    logic        hit;
    logic        tk;
    logic [1:0]  slot;
    logic [31:0] tgt;
    logic [2:0]  n;
    logic [31:0] nxt;
    logic        t0;
  } vec_t;

  // start, hit, taken, slot, target, pushed, next pc, head0 taken flag
  localparam vec_t VECS [8] = '{
    '{32'h1000, 1'b1, 1'b0, 2'd0, 32'h0,    3'd4, 32'h1010, 1'b0}, // R2
    '{32'h1008, 1'b1, 1'b0, 2'd0, 32'h0,    3'd2, 32'h1010, 1'b0}, // R3
    '{32'h100C, 1'b1, 1'b0, 2'd0, 32'h0,    3'd1, 32'h1010, 1'b0}, // R3 last slot
    '{32'h1000, 1'b1, 1'b1, 2'd1, 32'h2000, 3'd2, 32'h2000, 1'b0}, // R4
    '{32'h1004, 1'b1, 1'b1, 2'd1, 32'h2040, 3'd1, 32'h2040, 1'b1}, // R4 branch at start
    '{32'h1008, 1'b1, 1'b1, 2'd1, 32'h3000, 3'd2, 32'h1010, 1'b0}, // R5 stale slot
    '{32'h1000, 1'b0, 1'b0, 2'd0, 32'h0,    3'd0, 32'h1000, 1'b0}, // R6 miss
    '{32'h1020, 1'b1, 1'b1, 2'd3, 32'h1100, 3'd4, 32'h1100, 1'b0}  // R4 last slot
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       fetch_pc;
  logic [BI*32-1:0]  blk_data;
  logic              blk_hit;
  logic              bp_taken;
  logic [1:0]        bp_slot;
  logic [31:0]       bp_target;
  logic              redir_valid;
  logic [31:0]       redir_pc;
  logic [1:0]        deq_cnt;
  logic [DW-1:0]     head_valid;
  logic [DW*32-1:0]  head_insn;
  logic [DW*32-1:0]  head_pc;
  logic [DW-1:0]     head_taken;
  logic [4:0]        q_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_block_unit #(.BLOCK_INSNS(BI), .Q_DEPTH(QD), .DEC_W(DW), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .blk_data(blk_data),
    .blk_hit(blk_hit), .bp_taken(bp_taken), .bp_slot(bp_slot), .bp_target(bp_target),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .deq_cnt(deq_cnt),
    .head_valid(head_valid), .head_insn(head_insn), .head_pc(head_pc),
    .head_taken(head_taken), .q_count(q_count)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  // cache model: answers for the block holding fetch_pc
  always_comb begin
    for (int s = 0; s < BI; s++)
      blk_data[s*32 +: 32] = word_at((fetch_pc & ~32'hF) + 32'(s*4));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic redirect_to(input logic [31:0] a);
    @(negedge clk);
    redir_valid = 1'b1; redir_pc = a; blk_hit = 1'b0; bp_taken = 1'b0; deq_cnt = 2'd0;
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; blk_hit = 1'b0; bp_taken = 1'b0; bp_slot = '0; bp_target = '0;
    redir_valid = 1'b0; redir_pc = '0; deq_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 fetch_pc", fetch_pc, 32'h0);
    chk("R1 q_count", 32'(q_count), 32'd0);
    chk("R1 head_valid", 32'(head_valid), 32'd0);

    // table walk: each vector from an empty queue
    for (int v = 0; v < 8; v++) begin
      redirect_to(VECS[v].start);
      blk_hit = VECS[v].hit; bp_taken = VECS[v].tk;
      bp_slot = VECS[v].slot; bp_target = VECS[v].tgt;
      @(negedge clk);
      blk_hit = 1'b0; bp_taken = 1'b0;
      chk($sformatf("R2-vec%0d next pc", v), fetch_pc, VECS[v].nxt);
      chk($sformatf("R3 vec%0d count", v), 32'(q_count), 32'(VECS[v].n));
      chk($sformatf("R8 vec%0d head_valid", v), 32'(head_valid),
          32'((VECS[v].n > 1) ? 2'b11 : (VECS[v].n == 1) ? 2'b01 : 2'b00));
      if (VECS[v].n != 0) begin
        chk($sformatf("R2 vec%0d head0 pc", v), head_pc[31:0], VECS[v].start);
        chk($sformatf("R2 vec%0d head0 insn", v), head_insn[31:0], word_at(VECS[v].start));
        chk($sformatf("R4 vec%0d head0 taken", v), 32'(head_taken[0]), 32'(VECS[v].t0));
      end
      if (VECS[v].n > 1)
        chk($sformatf("R4 vec%0d head1 pc", v), head_pc[63:32], VECS[v].start + 32'd4);
    end
    // R4 flag on the branch slot (vector 3: slot 1 is second entry)
    redirect_to(32'h1000);
    blk_hit = 1'b1; bp_taken = 1'b1; bp_slot = 2'd1; bp_target = 32'h2000;
    @(negedge clk);
    blk_hit = 1'b0; bp_taken = 1'b0;
    chk("R4 branch slot flag", 32'(head_taken), 32'b10);

    // fill until the free-space stall (R7)
    redirect_to(32'h4000);
    blk_hit = 1'b1;
    repeat (5) @(negedge clk);
    blk_hit = 1'b0;
    chk("R7 count at stall", 32'(q_count), 32'd16);
    chk("R7 pc held at stall", fetch_pc, 32'h4040);
    chk("R8 head0 pc", head_pc[31:0], 32'h4000);
    chk("R8 head1 pc", head_pc[63:32], 32'h4004);
    // pop only
    deq_cnt = 2'd2;
    @(negedge clk);
    chk("R8 pop two", 32'(q_count), 32'd14);
    chk("R8 head after pop", head_pc[31:0], 32'h4008);
    // push and pop together
    blk_hit = 1'b1;
    @(negedge clk);
    blk_hit = 1'b0;
    chk("R8 push and pop", 32'(q_count), 32'd16);
    chk("R8 head after both", head_pc[31:0], 32'h4010);
    chk("R2 pc after fill", fetch_pc, 32'h4050);
    // over-wide pop request clamps to DEC_W
    deq_cnt = 2'd3;
    @(negedge clk);
    chk("R8 pop clamp width", 32'(q_count), 32'd14);
    // redirect overrides hit and pop (R9)
    redir_valid = 1'b1; redir_pc = 32'h5000; blk_hit = 1'b1; deq_cnt = 2'd2;
    @(negedge clk);
    redir_valid = 1'b0; blk_hit = 1'b0;
    chk("R9 flushed count", 32'(q_count), 32'd0);
    chk("R9 redirect pc", fetch_pc, 32'h5000);
    chk("R9 head_valid", 32'(head_valid), 32'd0);
    // pop from empty clamps to zero
    @(negedge clk);
    chk("R8 empty pop", 32'(q_count), 32'd0);
    // miss keeps pc and queue (R6)
    @(negedge clk);
    chk("R6 pc held on miss", fetch_pc, 32'h5000);
    deq_cnt = 2'd0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule